// File: doc/BRIEF.md
# Page-Buffered Nonvolatile Write Controller

This block sits between the byte-write side of a serial-bus slave and a nonvolatile array made of 8-byte rows. The first data byte of a transaction carries a memory address. That address picks the row and the starting byte slot. Each later byte goes to the next slot through an internal counter. The counter wraps inside the same row, so extra bytes overwrite the ones written earlier in that transaction. The page buffer is filled from the stored row when the first byte arrives. Bytes the transaction never touches therefore keep their old values.

When the stop pulse ends a transaction that wrote at least one byte, the block issues a single commit. The commit carries the row's base address and the full merged row, and the same row is written back into a register array that models the cells. The block then stays busy for a fixed number of clock cycles. While busy it ignores byte strobes and stop pulses. The slave in front of it uses the busy flag to refuse its own address.

Top module: `nvm_page_writer`

## Requirements
- R1: After reset, `busy` and `commit_req` are low and every stored row reads as all zeros.
- R2: A strobe with no transaction open latches `wr_addr`. The commit base is that address with its low 3 bits cleared, and the byte lands in slot `wr_addr[2:0]`. In `commit_data`, slot k sits at bits [8k+7:8k].
- R3: Each further strobe in the same transaction ignores `wr_addr` and writes the slot after the previous one.
- R4: After slot 7 the counter returns to slot 0 of the same row. A slot written twice in one transaction holds the later byte.
- R5: Slots not written in a transaction carry the row's contents from the last commit to that row.
- R6: A stop pulse in an open transaction makes `commit_req` high for exactly one cycle, starting one clock edge after the stop, with `commit_base` and `commit_data` valid in that cycle.
- R7: `busy` rises together with `commit_req` and stays high for exactly WRITE_CYCLES cycles.
- R8: While `busy` is high, strobes and stop pulses have no effect: they store no data and start no commit.
- R9: A stop pulse with no byte written since the last commit starts no commit and leaves `busy` low.
- R10: A strobe in the same cycle as an accepted stop pulse is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | One data byte is present this cycle |
| wr_addr | input | ADDR_W | Memory address, used only on the first byte of a transaction |
| wr_data | input | 8 | Data byte |
| stop_pulse | input | 1 | End of the bus transaction |
| commit_req | output | 1 | One-cycle row-write request |
| commit_base | output | ADDR_W | Row base address, low 3 bits zero |
| commit_data | output | 8*ROW_BYTES | Full merged row, slot 0 in the low byte |
| busy | output | 1 | Write time in progress |

## Verification
A byte strobe updates the page buffer at the next rising edge. Its effect first shows in the commit of that transaction. The commit request, base and row, and the rise of busy, are all due one edge after the stop cycle. Busy then falls WRITE_CYCLES edges after it rose. The bench drives every input on the falling edge, and it reads the commit outputs and busy on the falling edge after the stop. From that point it counts falling edges with busy high until busy drops. Expected rows come from a bench-side copy of the array that applies slot wrapping, merging and the ignore rules.

// File: rtl/nvm_pw_pkg.sv
package nvm_pw_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] nv_byte_t;
  typedef enum logic {TMR_IDLE = 1'b0, TMR_RUN = 1'b1} tmr_state_e;
endpackage

// File: rtl/pw_row_store.sv
module pw_row_store #(
  parameter int unsigned ROWS     = 32,
  parameter int unsigned ROW_BITS = 64,
  localparam int unsigned RIDX_W  = $clog2(ROWS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en_i,
  input  logic [RIDX_W-1:0]   wr_row_i,
  input  logic [ROW_BITS-1:0] wr_data_i,
  input  logic [RIDX_W-1:0]   rd_row_i,
  output logic [ROW_BITS-1:0] rd_data_o
);
  logic [ROW_BITS-1:0] rows_q [ROWS];

  for (genvar g = 0; g < ROWS; g++) begin : g_row
    logic row_en;
    assign row_en = wr_en_i && (wr_row_i == RIDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rows_q[g] <= '0;
      end else if (row_en) begin
        rows_q[g] <= wr_data_i;
      end
    end
  end

  assign rd_data_o = rows_q[rd_row_i];
endmodule

// File: rtl/pw_page_buffer.sv
module pw_page_buffer
  import nvm_pw_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned ROW_BYTES = 8,
  localparam int unsigned OFS_W    = $clog2(ROW_BYTES),
  localparam int unsigned ROW_W    = ADDR_W - OFS_W,
  localparam int unsigned ROW_BITS = ROW_BYTES * BYTE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                take_i,
  input  logic                clear_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  nv_byte_t            data_i,
  input  logic [ROW_BITS-1:0] preload_i,
  output logic [ROW_W-1:0]    rd_row_o,
  output logic [ROW_W-1:0]    row_o,
  output logic [ROW_BITS-1:0] page_o,
  output logic                active_o
);
  logic                active_q, active_d;
  logic [ROW_W-1:0]    row_q, row_d;
  logic [OFS_W-1:0]    ofs_q, ofs_d;
  logic [ROW_BITS-1:0] page_q, page_d;
  logic [OFS_W-1:0]    sel_ofs;
  logic [ROW_BITS-1:0] base_page;
  logic                upd_en;

  assign sel_ofs   = active_q ? ofs_q : addr_i[OFS_W-1:0];
  assign base_page = active_q ? page_q : preload_i;
  assign upd_en    = take_i | clear_i;

  always_comb begin
    active_d = active_q;
    row_d    = row_q;
    ofs_d    = ofs_q;
    page_d   = page_q;
    if (take_i) begin
      active_d = 1'b1;
      if (!active_q) begin
        row_d = addr_i[ADDR_W-1:OFS_W];
      end
      page_d = base_page;
      for (int k = 0; k < ROW_BYTES; k++) begin
        if (sel_ofs == OFS_W'(k)) begin
          page_d[k*BYTE_W +: BYTE_W] = data_i;
        end
      end
      ofs_d = sel_ofs + OFS_W'(1);
    end
    if (clear_i) begin
      active_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      row_q    <= '0;
      ofs_q    <= '0;
      page_q   <= '0;
    end else if (upd_en) begin
      active_q <= active_d;
      row_q    <= row_d;
      ofs_q    <= ofs_d;
      page_q   <= page_d;
    end
  end

  assign rd_row_o = addr_i[ADDR_W-1:OFS_W];
  assign row_o    = row_q;
  assign page_o   = page_q;
  assign active_o = active_q;

  AST_ROW_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && active_q) |=> (row_q == $past(row_q))); // R3
endmodule

// File: rtl/pw_write_timer.sv
module pw_write_timer
  import nvm_pw_pkg::*;
#(
  parameter int unsigned WRITE_CYCLES = 40,
  localparam int unsigned CNT_W       = $clog2(WRITE_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o
);
  tmr_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             tmr_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      TMR_IDLE: begin
        if (start_i) begin
          state_d = TMR_RUN;
          cnt_d   = CNT_W'(WRITE_CYCLES - 1);
        end
      end
      TMR_RUN: begin
        if (cnt_q == '0) begin
          state_d = TMR_IDLE;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      default: state_d = TMR_IDLE;
    endcase
  end

  assign tmr_en = start_i | (state_q == TMR_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TMR_IDLE;
      cnt_q   <= '0;
    end else if (tmr_en) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign busy_o = (state_q == TMR_RUN);

  AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i)); // R7
  AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !busy_o); // R8
endmodule

// File: rtl/nvm_page_writer.sv
module nvm_page_writer
  import nvm_pw_pkg::*;
#(
  parameter int unsigned ADDR_W       = 8,
  parameter int unsigned ROW_BYTES    = 8,
  parameter int unsigned WRITE_CYCLES = 40,
  localparam int unsigned OFS_W       = $clog2(ROW_BYTES),
  localparam int unsigned ROW_W       = ADDR_W - OFS_W,
  localparam int unsigned ROWS        = 2 ** ROW_W,
  localparam int unsigned ROW_BITS    = ROW_BYTES * BYTE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_stb,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [BYTE_W-1:0]   wr_data,
  input  logic                stop_pulse,
  output logic                commit_req,
  output logic [ADDR_W-1:0]   commit_base,
  output logic [ROW_BITS-1:0] commit_data,
  output logic                busy
);
  logic                take;
  logic                stop_go;
  logic                buf_active;
  logic [ROW_W-1:0]    buf_row;
  logic [ROW_W-1:0]    rd_row;
  logic [ROW_BITS-1:0] buf_page;
  logic [ROW_BITS-1:0] row_rd_data;

  logic                req_q, req_d;
  logic [ADDR_W-1:0]   base_q, base_d;
  logic [ROW_BITS-1:0] data_q, data_d;

  // A stop closes only an open transaction; a strobe in the same cycle is lost.
  assign stop_go = stop_pulse && buf_active && !busy;
  assign take    = wr_stb && !busy && !stop_pulse;

  pw_page_buffer #(
    .ADDR_W    (ADDR_W),
    .ROW_BYTES (ROW_BYTES)
  ) u_buffer (
    .clk       (clk),
    .rst_n     (rst_n),
    .take_i    (take),
    .clear_i   (stop_go),
    .addr_i    (wr_addr),
    .data_i    (wr_data),
    .preload_i (row_rd_data),
    .rd_row_o  (rd_row),
    .row_o     (buf_row),
    .page_o    (buf_page),
    .active_o  (buf_active)
  );

  pw_row_store #(
    .ROWS     (ROWS),
    .ROW_BITS (ROW_BITS)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (req_q),
    .wr_row_i  (base_q[ADDR_W-1:OFS_W]),
    .wr_data_i (data_q),
    .rd_row_i  (rd_row),
    .rd_data_o (row_rd_data)
  );

  pw_write_timer #(
    .WRITE_CYCLES (WRITE_CYCLES)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (stop_go),
    .busy_o  (busy)
  );

  always_comb begin
    req_d  = stop_go;
    base_d = base_q;
    data_d = data_q;
    if (stop_go) begin
      base_d = {buf_row, OFS_W'(0)};
      data_d = buf_page;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
    end else begin
      req_q <= req_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      data_q <= '0;
    end else if (stop_go) begin
      base_q <= base_d;
      data_q <= data_d;
    end
  end

  assign commit_req  = req_q;
  assign commit_base = base_q;
  assign commit_data = data_q;

  AST_COMMIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    commit_req |=> !commit_req); // R6
  AST_BUSY_WITH_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    commit_req |-> busy); // R7
  AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(buf_page)); // R8
  AST_EMPTY_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_pulse && !buf_active) |=> !commit_req); // R9
endmodule

// File: tb/nvm_page_writer_bench.sv
module nvm_page_writer_bench;
  localparam int WC = 12;

  logic        clk;
  logic        rst_n;
  logic        wr_stb;
  logic [7:0]  wr_addr;
  logic [7:0]  wr_data;
  logic        stop_pulse;
  logic        commit_req;
  logic [7:0]  commit_base;
  logic [63:0] commit_data;
  logic        busy;

  int tests_run;
  int tests_failed;
  logic [63:0] model_mem [32];

  nvm_page_writer #(
    .ADDR_W       (8),
    .ROW_BYTES    (8),
    .WRITE_CYCLES (WC)
  ) u_nvm_page_writer (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_stb      (wr_stb),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .stop_pulse  (stop_pulse),
    .commit_req  (commit_req),
    .commit_base (commit_base),
    .commit_data (commit_data),
    .busy        (busy)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    tests_run++;
    if (!ok) begin
      tests_failed++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] put_byte(input logic [63:0] row, input int slot,
                                           input logic [7:0] b);
    logic [63:0] r;
    r = row;
    r[slot*8 +: 8] = b;
    return r;
  endfunction

  // One transaction of n bytes starting at addr, then stop and the busy window.
  task automatic run_txn(input logic [7:0] addr, input int n, input bit stb_at_stop,
                         input bit junk, input string tag);
    logic [63:0] exp;
    int slot;
    int cnt;
    exp  = model_mem[addr[7:3]];
    slot = int'(addr[2:0]);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_stb  = 1'b1;
      wr_addr = (i == 0) ? addr : 8'($urandom);
      wr_data = 8'($urandom);
      exp  = put_byte(exp, slot, wr_data);
      slot = (slot + 1) % 8;
    end
    @(negedge clk);
    wr_stb     = stb_at_stop;
    wr_addr    = 8'($urandom);
    wr_data    = 8'($urandom);
    stop_pulse = 1'b1;
    @(negedge clk);
    wr_stb     = 1'b0;
    stop_pulse = 1'b0;
    check(commit_req === 1'b1, "R6", "commit_req after stop", 64'(commit_req), 64'd1);
    check(commit_base === {addr[7:3], 3'b000}, "R2", "commit_base",
          64'(commit_base), 64'({addr[7:3], 3'b000}));
    check(commit_data === exp, tag, "commit_data row", commit_data, exp);
    model_mem[addr[7:3]] = exp;
    cnt = 0;
    while (busy === 1'b1 && cnt < 1000) begin
      cnt++;
      if (cnt > 1) begin
        check(commit_req === 1'b0, (cnt == 2) ? "R6" : "R8", "commit_req during busy",
              64'(commit_req), 64'd0);
      end
      if (junk) begin
        wr_stb     = 1'($urandom);
        stop_pulse = 1'($urandom);
        wr_addr    = 8'($urandom);
        wr_data    = 8'($urandom);
      end
      @(negedge clk);
    end
    wr_stb     = 1'b0;
    stop_pulse = 1'b0;
    check(cnt == WC, "R7", "busy length", 64'(cnt), 64'(WC));
  endtask

  task automatic empty_stop();
    @(negedge clk);
    stop_pulse = 1'b1;
    @(negedge clk);
    stop_pulse = 1'b0;
    check(commit_req === 1'b0, "R9", "commit_req after empty stop", 64'(commit_req), 64'd0);
    check(busy === 1'b0, "R9", "busy after empty stop", 64'(busy), 64'd0);
    @(negedge clk);
    check(busy === 1'b0, "R9", "busy one cycle later", 64'(busy), 64'd0);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests_run++;
    tests_failed++;
    $display("FAIL R6 watchdog expired: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd7215));
    tests_run    = 0;
    tests_failed = 0;
    for (int r = 0; r < 32; r++) model_mem[r] = '0;
    rst_n      = 1'b0;
    wr_stb     = 1'b0;
    wr_addr    = '0;
    wr_data    = '0;
    stop_pulse = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy === 1'b0, "R1", "busy after reset", 64'(busy), 64'd0);
    check(commit_req === 1'b0, "R1", "commit_req after reset", 64'(commit_req), 64'd0);

    run_txn(8'h13, 1, 1'b0, 1'b0, "R1");   // untouched slots read zero
    run_txn(8'h15, 2, 1'b0, 1'b0, "R5");   // merge with previous commit
    run_txn(8'h40, 8, 1'b0, 1'b0, "R2");   // full row from slot 0
    run_txn(8'h4A, 9, 1'b0, 1'b0, "R4");   // wrap, slot 2 overwritten
    run_txn(8'h4E, 3, 1'b0, 1'b0, "R4");   // slots 6, 7, 0
    empty_stop();
    run_txn(8'h61, 3, 1'b1, 1'b0, "R10");  // strobe beside stop dropped
    run_txn(8'h88, 2, 1'b0, 1'b1, "R3");   // junk while busy
    run_txn(8'h8B, 1, 1'b0, 1'b0, "R8");   // junk must not show here
    empty_stop();

    for (int t = 0; t < 40; t++) begin
      run_txn(8'($urandom), 1 + int'($urandom % 12), 1'($urandom), 1'($urandom), "R3");
    end
    empty_stop();
    finish_run();
  end
endmodule